// File: doc/BRIEF.md
# CAN Transmit Interrupt Status Aggregator

This block collects the transmit-side interrupt requests of one CAN channel into a single read-only 16-bit status word. It also drives one transmit interrupt line. It keeps a 2-bit result code for each transmit buffer and a per-buffer interrupt enable. It also keeps a channel abort-interrupt enable, a FIFO-transmit request flag with its enable, and a transmit-history request flag with its enable.

The transmit engine reports how a buffer finished with a one-cycle event that carries the buffer index and the 2-bit code. Software clears a code with a one-cycle strobe that carries the buffer index. Software loads all enables at once through a single write strobe. Both the global reset mode and the channel reset mode clear all state, and the status word reads zero while either mode is active.

Top module: `can_tx_irq_status`

## Requirements
- R1: Status bits 15..4 always read 0, and a write strobe on the status word (`sts_we_i`) changes no status bit and no state.
- R2: A result event loads `res_code_i` into buffer `res_idx_i` at the next clock edge. The codes are: 00 none, 01 abort done, 10 sent, 11 sent with an abort pending. A clear strobe sets the indexed code to 00. When an event and a clear arrive in the same cycle, the event wins.
- R3: Status bit 0 (transmit done) is 1 when at least one buffer has its enable at 1 and its code at 10 or 11.
- R4: Status bit 0 returns to 0 when every qualifying code has been cleared, or when the enables of those buffers have been cleared.
- R5: Status bit 1 (abort) becomes 1 when the abort enable is 1 and some code is 01. Clearing the abort enable does not clear it. It falls only when no code is 01.
- R6: Status bit 2 (FIFO transmit) equals the FIFO enable AND the FIFO request flag.
- R7: Status bit 3 (transmit history) equals the history enable AND the history request flag.
- R8: While `glb_rst_mode_i` or `ch_rst_mode_i` is high, status bits 3..0 read 0 in that same cycle. At every edge during the mode, all codes, flags, enables and the abort hold are cleared, and events and writes are ignored.
- R9: A request flag is set by its set strobe and cleared by its clear strobe. When both strobes arrive together, the set wins.
- R10: `irq_o` is a register that equals the OR of status bits 3..0 as they were in the previous cycle.
- R11: Asserting `rst_ni` low clears all state and `irq_o` at once.
- R12: `enable_i` is loaded on `enable_we_i`. Bits [NUM_BUF-1:0] are the per-buffer enables, bit NUM_BUF is the abort enable, bit NUM_BUF+1 is the FIFO enable, and bit NUM_BUF+2 is the history enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| glb_rst_mode_i | input | 1 | Global reset mode active |
| ch_rst_mode_i | input | 1 | Channel reset mode active |
| enable_we_i | input | 1 | Load all enables |
| enable_i | input | NUM_BUF+3 | Enable word (layout in R12) |
| res_evt_i | input | 1 | Result event from the transmit engine |
| res_idx_i | input | IDX_W | Buffer index of the event |
| res_code_i | input | 2 | Result code of the event |
| res_clr_i | input | 1 | Software clear of a result code |
| res_clr_idx_i | input | IDX_W | Buffer index of the clear |
| fifo_req_set_i | input | 1 | Set the FIFO transmit request |
| fifo_req_clr_i | input | 1 | Clear the FIFO transmit request |
| hist_req_set_i | input | 1 | Set the history request |
| hist_req_clr_i | input | 1 | Clear the history request |
| sts_we_i | input | 1 | Write strobe on the status word (ignored) |
| sts_wdata_i | input | 16 | Write data for the status word (ignored) |
| status_o | output | 16 | Status word |
| irq_o | output | 1 | Registered transmit interrupt |

## Verification
Several functions can fall in the same cycle:
- A result event and a software clear can target the same buffer.
- A request flag can be set and cleared at once.
- A reset mode can coincide with events.
- An enable can be withdrawn while a code stays pending.

The bench applies each of these as a directed case and also mixes them at random. A behavioural reference model holds per-buffer codes, flags, enables and the abort hold. The model applies the stated priorities: event over clear, set over clear, and reset mode over everything. The status word and the interrupt line are compared against this model on every clock.

// File: rtl/can_txirq_pkg.sv
package can_txirq_pkg;
  typedef enum logic [1:0] {
    RES_NONE      = 2'b00,
    RES_ABORTED   = 2'b01,
    RES_SENT      = 2'b10,
    RES_SENT_ABRQ = 2'b11
  } tx_res_e;

  localparam int unsigned STS_W      = 16;
  localparam int unsigned STS_TXDONE = 0;
  localparam int unsigned STS_ABORT  = 1;
  localparam int unsigned STS_FIFO   = 2;
  localparam int unsigned STS_HIST   = 3;
  localparam int unsigned STS_USED   = 4;
endpackage

// File: rtl/can_txirq_buf_bank.sv
module can_txirq_buf_bank
  import can_txirq_pkg::*;
#(
  parameter int unsigned NUM_BUF = 4,
  parameter int unsigned IDX_W   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               flush_i,
  input  logic               evt_i,
  input  logic [IDX_W-1:0]   evt_idx_i,
  input  tx_res_e            evt_code_i,
  input  logic               clr_i,
  input  logic [IDX_W-1:0]   clr_idx_i,
  input  logic [NUM_BUF-1:0] buf_ie_i,
  output logic               done_hit_o,
  output logic               abort_any_o
);
  tx_res_e              code_q [NUM_BUF];
  logic [NUM_BUF-1:0]   done_vec;
  logic [NUM_BUF-1:0]   abort_vec;

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_buf
    logic evt_hit, clr_hit;
    assign evt_hit = evt_i && (evt_idx_i == IDX_W'(g));
    assign clr_hit = clr_i && (clr_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      code_q[g] <= RES_NONE;
      else if (flush_i) code_q[g] <= RES_NONE;
      else if (evt_hit) code_q[g] <= evt_code_i;   // event beats clear
      else if (clr_hit) code_q[g] <= RES_NONE;
    end

    // upper code bit set means the frame went out
    assign done_vec[g]  = buf_ie_i[g] && code_q[g][1];
    assign abort_vec[g] = (code_q[g] == RES_ABORTED);
  end

  assign done_hit_o  = |done_vec;
  assign abort_any_o = |abort_vec;
endmodule

// File: rtl/can_txirq_req_flag.sv
module can_txirq_req_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic ie_i,
  output logic req_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (flush_i) flag_q <= 1'b0;
    else if (set_i)   flag_q <= 1'b1;
    else if (clr_i)   flag_q <= 1'b0;
  end

  assign req_o = ie_i && flag_q;
endmodule

// File: rtl/can_tx_irq_status.sv
module can_tx_irq_status
  import can_txirq_pkg::*;
#(
  parameter  int unsigned NUM_BUF = 4,
  localparam int unsigned IDX_W   = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
  localparam int unsigned EN_W    = NUM_BUF + 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             glb_rst_mode_i,
  input  logic             ch_rst_mode_i,
  input  logic             enable_we_i,
  input  logic [EN_W-1:0]  enable_i,
  input  logic             res_evt_i,
  input  logic [IDX_W-1:0] res_idx_i,
  input  logic [1:0]       res_code_i,
  input  logic             res_clr_i,
  input  logic [IDX_W-1:0] res_clr_idx_i,
  input  logic             fifo_req_set_i,
  input  logic             fifo_req_clr_i,
  input  logic             hist_req_set_i,
  input  logic             hist_req_clr_i,
  input  logic             sts_we_i,
  input  logic [STS_W-1:0] sts_wdata_i,
  output logic [STS_W-1:0] status_o,
  output logic             irq_o
);
  localparam int unsigned EN_ABORT = NUM_BUF;
  localparam int unsigned EN_FIFO  = NUM_BUF + 1;
  localparam int unsigned EN_HIST  = NUM_BUF + 2;

  logic                flush;
  logic [EN_W-1:0]     en_q;
  logic                done_hit, abort_any;
  logic                abort_hold_q, abort_bit;
  logic                fifo_bit, hist_bit;
  logic [STS_USED-1:0] sts_live;
  logic                sts_unused;

  assign flush      = glb_rst_mode_i || ch_rst_mode_i;
  assign sts_unused = ^{sts_we_i, sts_wdata_i};  // status word is read-only

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          en_q <= '0;
    else if (flush)       en_q <= '0;
    else if (enable_we_i) en_q <= enable_i;
  end

  can_txirq_buf_bank #(
    .NUM_BUF (NUM_BUF),
    .IDX_W   (IDX_W)
  ) u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush),
    .evt_i       (res_evt_i),
    .evt_idx_i   (res_idx_i),
    .evt_code_i  (tx_res_e'(res_code_i)),
    .clr_i       (res_clr_i),
    .clr_idx_i   (res_clr_idx_i),
    .buf_ie_i    (en_q[NUM_BUF-1:0]),
    .done_hit_o  (done_hit),
    .abort_any_o (abort_any)
  );

  // abort bit survives enable removal; only the codes release it
  assign abort_bit = abort_any && (en_q[EN_ABORT] || abort_hold_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    abort_hold_q <= 1'b0;
    else if (flush) abort_hold_q <= 1'b0;
    else            abort_hold_q <= abort_bit;
  end

  can_txirq_req_flag u_fifo_flag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .set_i   (fifo_req_set_i),
    .clr_i   (fifo_req_clr_i),
    .ie_i    (en_q[EN_FIFO]),
    .req_o   (fifo_bit)
  );

  can_txirq_req_flag u_hist_flag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .set_i   (hist_req_set_i),
    .clr_i   (hist_req_clr_i),
    .ie_i    (en_q[EN_HIST]),
    .req_o   (hist_bit)
  );

  always_comb begin
    sts_live             = '0;
    sts_live[STS_TXDONE] = done_hit;
    sts_live[STS_ABORT]  = abort_bit;
    sts_live[STS_FIFO]   = fifo_bit;
    sts_live[STS_HIST]   = hist_bit;
    if (flush) sts_live = '0;
  end

  assign status_o = {{(STS_W-STS_USED){1'b0}}, sts_live};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |sts_live;
  end
endmodule

// File: rtl/can_txirq_checker.sv
module can_txirq_checker
  import can_txirq_pkg::*;
#(
  parameter  int unsigned NUM_BUF = 4,
  localparam int unsigned IDX_W   = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
  localparam int unsigned EN_W    = NUM_BUF + 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             glb_rst_mode_i,
  input logic             ch_rst_mode_i,
  input logic             enable_we_i,
  input logic [EN_W-1:0]  enable_i,
  input logic             res_evt_i,
  input logic [IDX_W-1:0] res_idx_i,
  input logic [1:0]       res_code_i,
  input logic             res_clr_i,
  input logic [IDX_W-1:0] res_clr_idx_i,
  input logic             fifo_req_set_i,
  input logic             fifo_req_clr_i,
  input logic             hist_req_set_i,
  input logic             hist_req_clr_i,
  input logic             sts_we_i,
  input logic [STS_W-1:0] sts_wdata_i,
  input logic [STS_W-1:0] status_o,
  input logic             irq_o
);
  logic mode;
  assign mode = glb_rst_mode_i || ch_rst_mode_i;

  a_r1_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[STS_W-1:STS_USED] == '0);

  a_r8_mode_silences: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode |-> status_o[STS_USED-1:0] == '0);

  a_r10_irq_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_o == $past(|status_o[STS_USED-1:0]));

  a_r5_abort_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[STS_ABORT] && !res_evt_i && !res_clr_i && !mode)
    |=> (status_o[STS_ABORT] || glb_rst_mode_i || ch_rst_mode_i));

  a_r6_fifo_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_req_clr_i && !fifo_req_set_i) |=> !status_o[STS_FIFO]);

  a_r7_hist_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hist_req_clr_i && !hist_req_set_i) |=> !status_o[STS_HIST]);
endmodule

bind can_tx_irq_status can_txirq_checker #(.NUM_BUF(NUM_BUF)) u_chk (.*);

// File: tb/can_tx_irq_status_bench.sv
module can_tx_irq_status_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int IW = 2;
  localparam int EW = NB + 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          glb_rst_mode_i = 0, ch_rst_mode_i = 0;
  logic          enable_we_i = 0;
  logic [EW-1:0] enable_i = '0;
  logic          res_evt_i = 0;
  logic [IW-1:0] res_idx_i = '0;
  logic [1:0]    res_code_i = '0;
  logic          res_clr_i = 0;
  logic [IW-1:0] res_clr_idx_i = '0;
  logic          fifo_req_set_i = 0, fifo_req_clr_i = 0;
  logic          hist_req_set_i = 0, hist_req_clr_i = 0;
  logic          sts_we_i = 0;
  logic [15:0]   sts_wdata_i = '0;
  logic [15:0]   status_o;
  logic          irq_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  can_tx_irq_status #(.NUM_BUF(NB)) u_can_tx_irq_status (.*);

  // reference model
  int m_code [NB];
  bit m_ie [NB];
  bit m_aie, m_fie, m_hie, m_fflag, m_hflag, m_ahold, m_irq;

  function automatic bit m_any01();
    for (int i = 0; i < NB; i++) if (m_code[i] == 1) return 1;
    return 0;
  endfunction

  function automatic logic [15:0] m_status();
    logic [15:0] s = '0;
    if (glb_rst_mode_i || ch_rst_mode_i) return s;
    for (int i = 0; i < NB; i++) if (m_ie[i] && m_code[i] >= 2) s[0] = 1;
    s[1] = m_any01() && (m_aie || m_ahold);
    s[2] = m_fie && m_fflag;
    s[3] = m_hie && m_hflag;
    return s;
  endfunction

  task automatic m_clear();
    for (int i = 0; i < NB; i++) begin m_code[i] = 0; m_ie[i] = 0; end
    m_aie = 0; m_fie = 0; m_hie = 0; m_fflag = 0; m_hflag = 0; m_ahold = 0;
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_clear(); m_irq = 0;
    end else begin
      logic [15:0] cur;
      cur = m_status();
      m_irq = |cur[3:0];
      if (glb_rst_mode_i || ch_rst_mode_i) m_clear();
      else begin
        m_ahold = cur[1];
        for (int i = 0; i < NB; i++) begin
          if (res_evt_i && res_idx_i == IW'(i)) m_code[i] = res_code_i;
          else if (res_clr_i && res_clr_idx_i == IW'(i)) m_code[i] = 0;
        end
        if (fifo_req_set_i) m_fflag = 1; else if (fifo_req_clr_i) m_fflag = 0;
        if (hist_req_set_i) m_hflag = 1; else if (hist_req_clr_i) m_hflag = 0;
        if (enable_we_i) begin
          for (int i = 0; i < NB; i++) m_ie[i] = enable_i[i];
          m_aie = enable_i[NB]; m_fie = enable_i[NB+1]; m_hie = enable_i[NB+2];
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk_i) if (rst_ni && !done) begin
    logic [15:0] e;
    e = m_status();
    check(status_o[15:4] == e[15:4], "R1", status_o, e);
    check(status_o[0] == e[0], "R3", status_o, e);
    check(status_o[1] == e[1], "R5", status_o, e);
    check(status_o[2] == e[2], "R6", status_o, e);
    check(status_o[3] == e[3], "R7", status_o, e);
    check(irq_o == m_irq, "R10", 16'(irq_o), 16'(m_irq));
  end

  task automatic step();
    @(posedge clk_i); #1;
    enable_we_i = 0; res_evt_i = 0; res_clr_i = 0;
    fifo_req_set_i = 0; fifo_req_clr_i = 0; hist_req_set_i = 0; hist_req_clr_i = 0;
    sts_we_i = 0;
  endtask

  task automatic set_en(input logic [EW-1:0] v);
    enable_we_i = 1; enable_i = v; step();
  endtask

  task automatic evt(input int idx, input int code);
    res_evt_i = 1; res_idx_i = IW'(idx); res_code_i = 2'(code); step();
  endtask

  task automatic clr(input int idx);
    res_clr_i = 1; res_clr_idx_i = IW'(idx); step();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    check(status_o == 0 && irq_o == 0, "R11", status_o, 16'h0);
    rst_ni = 1;
    step();

    set_en(7'h7F);  // R12 all enables on
    evt(0, 2);
    check(status_o == 16'h0001, "R2", status_o, 16'h0001);
    step();
    check(irq_o == 1, "R10", 16'(irq_o), 16'h1);
    evt(2, 3);
    clr(0);
    check(status_o[0] == 1, "R3", status_o, 16'h0001);
    clr(2);
    check(status_o[0] == 0, "R4", status_o, 16'h0000);

    evt(1, 2);
    set_en(7'h7D);  // drop buffer 1 enable, R12
    check(status_o[0] == 0, "R4", status_o, 16'h0000);
    set_en(7'h7F);
    check(status_o[0] == 1, "R12", status_o, 16'h0001);
    clr(1);

    evt(3, 1);
    check(status_o[1] == 1, "R5", status_o, 16'h0002);
    set_en(7'h6F);  // abort enable off
    check(status_o[1] == 1, "R5", status_o, 16'h0002);
    clr(3);
    check(status_o[1] == 0, "R5", status_o, 16'h0000);
    evt(3, 1);
    check(status_o[1] == 0, "R5", status_o, 16'h0000);
    set_en(7'h7F);
    check(status_o[1] == 1, "R5", status_o, 16'h0002);
    clr(3);

    res_evt_i = 1; res_idx_i = 1; res_code_i = 2'b10;
    res_clr_i = 1; res_clr_idx_i = 1; step();
    check(status_o[0] == 1, "R2", status_o, 16'h0001);
    clr(1);

    fifo_req_set_i = 1; step();
    check(status_o[2] == 1, "R6", status_o, 16'h0004);
    set_en(7'h5F);
    check(status_o[2] == 0, "R6", status_o, 16'h0000);
    set_en(7'h7F);
    fifo_req_clr_i = 1; step();
    check(status_o[2] == 0, "R6", status_o, 16'h0000);
    fifo_req_set_i = 1; fifo_req_clr_i = 1; step();
    check(status_o[2] == 1, "R9", status_o, 16'h0004);

    hist_req_set_i = 1; hist_req_clr_i = 1; step();
    check(status_o[3] == 1, "R9", status_o, 16'h000C);
    set_en(7'h3F);
    check(status_o[3] == 0, "R7", status_o, 16'h0004);
    set_en(7'h7F);
    check(status_o[3] == 1, "R7", status_o, 16'h000C);

    evt(0, 3);
    sts_we_i = 1; sts_wdata_i = 16'hFFF0; step();
    check(status_o == 16'h000D, "R1", status_o, 16'h000D);
    sts_we_i = 1; sts_wdata_i = 16'h0000; step();
    check(status_o == 16'h000D, "R1", status_o, 16'h000D);

    glb_rst_mode_i = 1; #1;
    check(status_o == 0, "R8", status_o, 16'h0);
    evt(2, 2);
    glb_rst_mode_i = 0; #1;
    check(status_o == 0, "R8", status_o, 16'h0);
    set_en(7'h7F);
    check(status_o == 0, "R8", status_o, 16'h0);
    ch_rst_mode_i = 1; fifo_req_set_i = 1; step();
    ch_rst_mode_i = 0; #1;
    check(status_o == 0, "R8", status_o, 16'h0);

    for (int n = 0; n < 3000; n++) begin
      enable_we_i    = ($urandom % 8) == 0;
      enable_i       = EW'($urandom);
      res_evt_i      = ($urandom % 3) == 0;
      res_idx_i      = IW'($urandom);
      res_code_i     = 2'($urandom);
      res_clr_i      = ($urandom % 3) == 0;
      res_clr_idx_i  = IW'($urandom);
      fifo_req_set_i = ($urandom % 4) == 0;
      fifo_req_clr_i = ($urandom % 4) == 0;
      hist_req_set_i = ($urandom % 4) == 0;
      hist_req_clr_i = ($urandom % 4) == 0;
      sts_we_i       = ($urandom % 5) == 0;
      sts_wdata_i    = 16'($urandom);
      glb_rst_mode_i = ($urandom % 60) == 0;
      ch_rst_mode_i  = ($urandom % 60) == 0;
      step();
      glb_rst_mode_i = 0; ch_rst_mode_i = 0;
    end

    set_en(7'h7F);
    evt(1, 2);
    step();
    #(CLK_PERIOD/4);
    rst_ni = 0; #1;
    check(status_o == 0 && irq_o == 0, "R11", {status_o[15:1], irq_o}, 16'h0);
    step();
    rst_ni = 1;
    step();
    check(status_o == 0, "R11", status_o, 16'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule